// File: doc/BRIEF.md
# SPI Flash Read Command Engine

This block is the read half of a serial-flash slave. It watches a chip-select, a serial clock and a serial data input, all oversampled by a fast system clock. It collects an 8-bit command and a 24-bit byte address, then streams bytes from a small on-chip array. It reads the array through a simple address/data port. Three read commands share one address counter: a plain read, a fast read that spends one byte of clocks on dummy bits, and a dual-output fast read that returns two bits per serial clock. The counter steps after every byte and folds back to zero past the top of the array, so one command can read the whole array over and over.

The host may idle the serial clock low (mode 0) or high (mode 3). Command bits are taken on rising serial-clock edges and data changes after falling edges. Output enables are returned as separate signals so that the pad ring can build the tri-state buffers. A `busy` input from the write side marks an internal program, erase or status-write cycle. A read command decoded while it is high is dropped.

Top module: `spi_flash_rd`

## Requirements
- R1: Command and address bits are taken from `si` on rising `sclk` edges while `cs_n` is low, most significant bit first: 8 command bits, then 24 address bits.
- R2: Command 8'h03 (plain read) has no dummy phase. Bit 7 of the first byte appears on `dq1_o` after the first falling `sclk` edge that follows the last address bit.
- R3: Command 8'h0B (fast read) lets 8 further rising edges pass as dummy bits, and their `si` values have no effect. Data then follows as in R2.
- R4: Command 8'h3B (dual fast read) has the same dummy phase as R3, then drives both pins. Each falling edge puts the odd bit of a pair on `dq1_o` and the even bit on `dq0_o`, in the order (7,6), (5,4), (3,2), (1,0). A byte therefore takes 4 clocks.
- R5: Single-pin reads send each byte MSB first on `dq1_o` with `dq1_oe` high. `dq0_oe` stays low. The output changes only after falling edges and holds while `sclk` is high.
- R6: The array address is the low ADDR_W bits of the 24-bit address, and the upper bits are ignored. It advances by one per byte, and from 2**ADDR_W-1 it goes to 0 while the read continues.
- R7: One system clock after `cs_n` goes high, both output enables are low. A command cut short at any bit is discarded, and the next select starts decoding a fresh command.
- R8: If `busy` is high when the 8th command bit is taken, the command is ignored. No output enable rises until `cs_n` goes high again.
- R9: Any command value other than the three read codes is ignored in the same way as R8.
- R10: After reset both output enables are low and `mem_addr` is 0.
- R11: Reads behave the same whether `sclk` idles low (mode 0) or high (mode 3) while deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| sclk | input | 1 | Serial clock, synchronous to clk |
| si | input | 1 | Serial command/address input |
| busy | input | 1 | High while a write-side cycle is running |
| mem_addr | output | ADDR_W | Array read address |
| mem_rdata | input | 8 | Array read data for mem_addr |
| dq0_o | output | 1 | Even data bit in dual mode |
| dq0_oe | output | 1 | Drive enable for dq0 |
| dq1_o | output | 1 | Serial data out; odd bit in dual mode |
| dq1_oe | output | 1 | Drive enable for dq1 |

## Verification
A bit counter off by one or a wrong dummy length shows up at the first data byte as a bit-shifted value, within eight serial clocks of the address. A wrong address counter shows up as a wrong byte at the next byte boundary, and at once when the read crosses the top of the array. A command state that survives deselect, or a busy check on the wrong bit, shows at the ports as an output enable that rises on a command that should be silent. Bytes are therefore compared across byte boundaries, across the wrap, in both clock idle levels, and after aborted and refused commands.

// File: rtl/spi_rd_pkg.sv
// Shared types for the SPI flash read engine.
package spi_rd_pkg;
    // Command decode phases.
    typedef enum logic [2:0] {
        PH_OPC,   // collecting command bits
        PH_ADR,   // collecting address bits
        PH_DMY,   // dummy clocks
        PH_DAT,   // streaming data
        PH_IGN    // command refused, wait for deselect
    } rd_phase_e;

    // Read flavour selected by the command.
    typedef enum logic [1:0] {
        RK_PLAIN,
        RK_FAST,
        RK_DUAL
    } rd_kind_e;
endpackage

// File: rtl/spi_rd_edge.sv
// Serial clock edge detector.
// Assumes sclk and cs_n are already synchronous to clk and that each sclk
// level lasts at least two clk cycles. Edges are reported only while selected.
module spi_rd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    output logic sel,
    output logic rise,
    output logic fall
);
    logic sclk_d;

    // Remember the previous serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk;
    end

    assign sel  = ~cs_n;
    assign rise = sel &  sclk & ~sclk_d;
    assign fall = sel & ~sclk &  sclk_d;
endmodule

// File: rtl/spi_rd_cmd.sv
// Command and address collector with the shared byte address counter.
// Assumes rise and fall never occur in the same clk cycle.
module spi_rd_cmd
    import spi_rd_pkg::*;
#(
    parameter int         ADDR_W  = 10,
    parameter logic [7:0] OP_READ = 8'h03,
    parameter logic [7:0] OP_FAST = 8'h0B,
    parameter logic [7:0] OP_DUAL = 8'h3B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rise,
    input  logic              si,
    input  logic              busy,
    input  logic              byte_take,
    output logic              in_data,
    output logic              dual,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam int SH_W = (ADDR_W > 8) ? ADDR_W - 1 : 7;

    rd_phase_e         phase;
    rd_kind_e          kind;
    logic [4:0]        cnt;
    logic [SH_W-1:0]   sh;
    logic [7:0]        opc_full;
    logic [ADDR_W-1:0] addr_full;
    logic              addr_load;

    assign opc_full  = {sh[6:0], si};
    assign addr_full = {sh[ADDR_W-2:0], si};
    assign addr_load = sel && rise && (phase == PH_ADR) && (cnt == 5'd23);
    assign in_data   = (phase == PH_DAT);
    assign dual      = (kind == RK_DUAL);

    // Phase sequencing and bit shifting on rising serial edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_OPC;
            kind  <= RK_PLAIN;
            cnt   <= 5'd0;
            sh    <= '0;
        end else if (!sel) begin
            phase <= PH_OPC;
            cnt   <= 5'd0;
        end else if (rise) begin
            sh <= {sh[SH_W-2:0], si};
            unique case (phase)
                PH_OPC: begin
                    if (cnt == 5'd7) begin
                        cnt <= 5'd0;
                        if (busy) begin
                            phase <= PH_IGN;
                        end else if (opc_full == OP_READ) begin
                            kind  <= RK_PLAIN;
                            phase <= PH_ADR;
                        end else if (opc_full == OP_FAST) begin
                            kind  <= RK_FAST;
                            phase <= PH_ADR;
                        end else if (opc_full == OP_DUAL) begin
                            kind  <= RK_DUAL;
                            phase <= PH_ADR;
                        end else begin
                            phase <= PH_IGN;
                        end
                    end else begin
                        cnt <= cnt + 5'd1;
                    end
                end
                PH_ADR: begin
                    if (cnt == 5'd23) begin
                        cnt   <= 5'd0;
                        phase <= (kind == RK_PLAIN) ? PH_DAT : PH_DMY;
                    end else begin
                        cnt <= cnt + 5'd1;
                    end
                end
                PH_DMY: begin
                    if (cnt == 5'd7) begin
                        cnt   <= 5'd0;
                        phase <= PH_DAT;
                    end else begin
                        cnt <= cnt + 5'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Byte address: load from the command, step once per byte, wrap naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)         mem_addr <= '0;
        else if (addr_load) mem_addr <= addr_full;
        else if (byte_take) mem_addr <= mem_addr + 1'b1;
    end

    // R1: the bit counter never leaves the 24-bit address window.
    a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < 5'd24);

    // R6: every byte handed to the output stage advances the address by one.
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        byte_take |=> (mem_addr == $past(mem_addr) + 1'b1));
endmodule

// File: rtl/spi_rd_out.sv
// Output shifter: single-pin or two-pin data on falling serial edges.
// Assumes in_data and dual stay constant while selected once data has begun.
module spi_rd_out (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       fall,
    input  logic       in_data,
    input  logic       dual,
    input  logic [7:0] mem_rdata,
    output logic       byte_take,
    output logic       dq0_o,
    output logic       dq0_oe,
    output logic       dq1_o,
    output logic       dq1_oe
);
    logic [2:0] pos;
    logic [7:0] sh;
    logic [7:0] cur;
    logic       drv_en;
    logic       dual_q;

    assign cur       = (pos == 3'd0) ? mem_rdata : sh;
    assign byte_take = sel && fall && in_data && (pos == 3'd0);
    assign dq1_oe    = drv_en;
    assign dq0_oe    = drv_en & dual_q;

    // Shift bits out after each falling edge of the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos    <= 3'd0;
            sh     <= 8'd0;
            drv_en <= 1'b0;
            dual_q <= 1'b0;
            dq0_o  <= 1'b0;
            dq1_o  <= 1'b0;
        end else if (!sel) begin
            pos    <= 3'd0;
            drv_en <= 1'b0;
            dual_q <= 1'b0;
        end else if (fall && in_data) begin
            drv_en <= 1'b1;
            dual_q <= dual;
            dq1_o  <= cur[7];
            if (dual) begin
                dq0_o <= cur[6];
                sh    <= {cur[5:0], 2'b00};
                pos   <= (pos == 3'd3) ? 3'd0 : pos + 3'd1;
            end else begin
                sh  <= {cur[6:0], 1'b0};
                pos <= pos + 3'd1;
            end
        end
    end

    // R7: deselect releases both pins on the next clock.
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (!dq1_oe && !dq0_oe));

    // R8: pins are driven only during a decoded data phase.
    a_r8_drive_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        dq1_oe |-> in_data);

    // R4: the second pin is driven only for the dual command, 4 slots per byte.
    a_r4_dual_pins: assert property (@(posedge clk) disable iff (!rst_n)
        dq0_oe |-> (dual && pos < 3'd4));
endmodule

// File: rtl/spi_flash_rd.sv
// Top of the SPI flash read engine: edge detect, command decode and output.
// Assumes serial inputs are synchronous to clk with levels of 2+ clk cycles.
module spi_flash_rd #(
    parameter int         ADDR_W  = 10,
    parameter logic [7:0] OP_READ = 8'h03,
    parameter logic [7:0] OP_FAST = 8'h0B,
    parameter logic [7:0] OP_DUAL = 8'h3B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              si,
    input  logic              busy,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              dq0_o,
    output logic              dq0_oe,
    output logic              dq1_o,
    output logic              dq1_oe
);
    logic sel, rise, fall;
    logic in_data, dual, byte_take;

    spi_rd_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sclk (sclk),
        .cs_n (cs_n),
        .sel  (sel),
        .rise (rise),
        .fall (fall)
    );

    spi_rd_cmd #(
        .ADDR_W (ADDR_W),
        .OP_READ(OP_READ),
        .OP_FAST(OP_FAST),
        .OP_DUAL(OP_DUAL)
    ) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .rise     (rise),
        .si       (si),
        .busy     (busy),
        .byte_take(byte_take),
        .in_data  (in_data),
        .dual     (dual),
        .mem_addr (mem_addr)
    );

    spi_rd_out u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .fall     (fall),
        .in_data  (in_data),
        .dual     (dual),
        .mem_rdata(mem_rdata),
        .byte_take(byte_take),
        .dq0_o    (dq0_o),
        .dq0_oe   (dq0_oe),
        .dq1_o    (dq1_o),
        .dq1_oe   (dq1_oe)
    );
endmodule

// File: tb/spi_flash_rd_tb.sv
// Self-checking bench for spi_flash_rd.
module spi_flash_rd_tb;
    localparam int AW   = 10;
    localparam int MASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          sclk = 1'b0;
    logic          si = 1'b0;
    logic          busy = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata;
    logic          dq0_o, dq0_oe, dq1_o, dq1_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic [7:0] pat(input int a);
        int t;
        t = (a * 29) ^ (a >> 4) ^ 8'h5A;
        return t[7:0];
    endfunction

    assign mem_rdata = pat(int'(mem_addr));

    spi_flash_rd #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si),
        .busy(busy), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .dq0_o(dq0_o), .dq0_oe(dq0_oe), .dq1_o(dq1_o), .dq1_oe(dq1_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (4) @(posedge clk);
    endtask

    task automatic begin_cmd(input bit mode3);
        @(negedge clk); sclk = mode3;
        half();
        @(negedge clk); cs_n = 1'b0;
        half();
    endtask

    task automatic end_cmd(input bit mode3);
        @(negedge clk); sclk = mode3;
        half();
        @(negedge clk); cs_n = 1'b1;
        half();
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk); sclk = 1'b0; si = b[i];
            half();
            @(negedge clk); sclk = 1'b1;
            half();
        end
    endtask

    // One byte on dq1; reports enables seen and stability over the high phase.
    task automatic rd_single(output logic [7:0] v, output bit oe1_all,
                             output bit oe_any, output bit oe0_any, output bit stable);
        logic b;
        v = 8'd0; oe1_all = 1'b1; oe_any = 1'b0; oe0_any = 1'b0; stable = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); sclk = 1'b0;
            half();
            b = dq1_o;
            v = {v[6:0], b};
            if (!dq1_oe) oe1_all = 1'b0;
            if (dq1_oe || dq0_oe) oe_any = 1'b1;
            if (dq0_oe) oe0_any = 1'b1;
            @(negedge clk); sclk = 1'b1;
            half();
            if (dq1_o !== b) stable = 1'b0;
        end
    endtask

    task automatic rd_dual(output logic [7:0] v, output bit oe_all);
        v = 8'd0; oe_all = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); sclk = 1'b0;
            half();
            v = {v[5:0], dq1_o, dq0_o};
            if (!(dq1_oe && dq0_oe)) oe_all = 1'b0;
            @(negedge clk); sclk = 1'b1;
            half();
        end
    endtask

    // Vector: {opcode[47:40], addr[39:16], nbytes[15:8], mode3[7:0]}
    localparam int NV = 6;
    localparam logic [47:0] VEC [NV] = '{
        {8'h03, 24'h000000, 8'd3, 8'd0},   // R2 plain, R1 decode
        {8'h0B, 24'h000123, 8'd3, 8'd0},   // R3 fast with dummy
        {8'h3B, 24'h0002F0, 8'd3, 8'd0},   // R4 dual
        {8'h03, 24'h0003FE, 8'd4, 8'd0},   // R6 wrap
        {8'h3B, 24'h0003FF, 8'd3, 8'd1},   // R4 R6 R11 dual wrap mode 3
        {8'h0B, 24'hABC012, 8'd2, 8'd1}    // R6 upper bits ignored, R11 mode 3
    };

    initial begin
        logic [7:0] v;
        bit oe1_all, oe_any, oe0_any, stable, oe_dual;

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk(!dq1_oe && !dq0_oe, "R10 enables after reset", {dq1_oe, dq0_oe}, 0);
        chk(mem_addr == '0, "R10 address after reset", int'(mem_addr), 0);

        // Table walk
        for (int r = 0; r < NV; r++) begin
            logic [7:0]  op;
            logic [23:0] ad;
            int          nb;
            bit          m3;
            op = VEC[r][47:40]; ad = VEC[r][39:16]; nb = int'(VEC[r][15:8]); m3 = VEC[r][0];
            begin_cmd(m3);
            send_byte(op);
            send_byte(ad[23:16]); send_byte(ad[15:8]); send_byte(ad[7:0]);
            if (op != 8'h03) send_byte(8'hC3);   // R3 dummy content ignored
            for (int k = 0; k < nb; k++) begin
                int exp_a;
                exp_a = (int'(ad) + k) & MASK;
                if (op == 8'h3B) begin
                    rd_dual(v, oe_dual);
                    chk(v == pat(exp_a), "R4 R6 dual byte", v, pat(exp_a));
                    chk(oe_dual, "R4 both pins enabled", 0, 1);
                end else begin
                    rd_single(v, oe1_all, oe_any, oe0_any, stable);
                    chk(v == pat(exp_a), "R2 R3 R6 R11 single byte", v, pat(exp_a));
                    chk(oe1_all && !oe0_any && stable, "R5 single pin behaviour",
                        {oe1_all, oe0_any, stable}, 3'b101);
                end
            end
            end_cmd(m3);
            chk(!dq1_oe && !dq0_oe, "R7 released after read", {dq1_oe, dq0_oe}, 0);
        end

        // R8: read refused while busy
        busy = 1'b1;
        begin_cmd(1'b0);
        send_byte(8'h03);
        busy = 1'b0;   // dropping busy later must not revive the command
        send_byte(8'h00); send_byte(8'h00); send_byte(8'h10);
        rd_single(v, oe1_all, oe_any, oe0_any, stable);
        rd_single(v, oe1_all, oe_any, oe0_any, stable);
        chk(!oe_any, "R8 no drive while busy", oe_any, 0);
        end_cmd(1'b0);
        begin_cmd(1'b0);
        send_byte(8'h03);
        send_byte(8'h00); send_byte(8'h00); send_byte(8'h10);
        rd_single(v, oe1_all, oe_any, oe0_any, stable);
        chk(v == pat(16), "R8 read after busy clears", v, pat(16));
        end_cmd(1'b0);

        // R9: unknown command ignored
        begin_cmd(1'b1);
        send_byte(8'h9F);
        send_byte(8'h00); send_byte(8'h00); send_byte(8'h20);
        rd_single(v, oe1_all, oe_any, oe0_any, stable);
        rd_single(v, oe1_all, oe_any, oe0_any, stable);
        chk(!oe_any, "R9 unknown command silent", oe_any, 0);
        end_cmd(1'b1);

        // R7: abort mid-address then a fresh command decodes correctly
        begin_cmd(1'b0);
        send_byte(8'h0B);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); sclk = 1'b0; si = 1'b1;
            half();
            @(negedge clk); sclk = 1'b1;
            half();
        end
        end_cmd(1'b0);
        begin_cmd(1'b0);
        send_byte(8'h03);
        send_byte(8'h00); send_byte(8'h00); send_byte(8'h55);
        rd_single(v, oe1_all, oe_any, oe0_any, stable);
        chk(v == pat(8'h55), "R7 fresh decode after abort", v, pat(8'h55));
        // R7: deselect mid-byte releases within one clock
        @(negedge clk); sclk = 1'b0;
        half();
        @(negedge clk); cs_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(!dq1_oe && !dq0_oe, "R7 release one clock after deselect",
            {dq1_oe, dq0_oe}, 0);
        half();

        // R4: dual mode bit order with a known byte at address 0x002
        begin_cmd(1'b0);
        send_byte(8'h3B);
        send_byte(8'h00); send_byte(8'h00); send_byte(8'h02);
        send_byte(8'h00);
        rd_dual(v, oe_dual);
        chk(v == pat(2) && oe_dual, "R4 dual pair order", v, pat(2));
        end_cmd(1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule